// File: doc/BRIEF.md
# Clock output stop and power-down controller

This block governs a bank of differential clock outputs. Each output is modelled as a true leg and a complement leg, and each leg has its own value and its own tri-state enable. The output clock is the reference clock divided by two. A single free-running phase register sets the timing for every output: the complement rises when the phase falls, and the complement falls when the phase rises.

Two asynchronous requests can stop the outputs.

- A power-down request parks every output.
- A stop request parks only the outputs configured as stoppable.

Each request is filtered by sampling it on complement-rising edges. Parking and enable changes take effect only on complement-falling edges, so an output always comes to rest high and restarts on a clean falling edge.

Configuration inputs choose the parked form: a driven true leg, or both legs undriven. Other configuration inputs enable each output and mark it as stoppable or free-running. A polarity pin, latched during reset, sets the active sense of the enable pins and of the two request pins. A further configuration bit can invert the sense of the two requests.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst` is high, every leg is undriven and low. `pol_pin` is captured only while `rst` is high, and later changes on it have no effect.
- R2: Each request is sampled on every clock edge at which the phase goes from 1 to 0 (a complement rise). The accepted state changes only when two consecutive samples agree, for both assertion and release. A request active for a single sample leaves the outputs running.
- R3: An enabled output that is not parked drives both legs. The true leg equals the phase, which toggles every clock cycle starting at 1 on the first edge after reset. The complement leg is its inverse.
- R4: An accepted power-down parks every enabled output on the next phase 0 to 1 edge. With `cfg_pd_tristate` at 0, the true leg is driven high and the complement is undriven and low. With `cfg_pd_tristate` at 1, both legs are undriven and low.
- R5: An accepted stop parks, on the same kind of edge, only the outputs whose `cfg_stoppable` bit is 1. The parked form follows `cfg_stop_tristate`, encoded as in R4.
- R6: An output whose `cfg_stoppable` bit is 0 keeps toggling while a stop is accepted.
- R7: After a stop release, all stopped outputs resume together. Each holds high for one more cycle and then falls, and the first fall comes 2 to 6 output periods (4 to 12 clocks) after the release.
- R8: An output is enabled when its `cfg_en` bit is 1 and its enable pin is active. A disabled output has both legs undriven and low, whatever the park state. Enable changes take effect on phase 0 to 1 edges.
- R9: With the latched polarity at 0, the enable pins are active-high and the requests are active-low. With it at 1, the enable pins are active-low and the requests are active-high. `cfg_req_inv` set to 1 inverts both requests.
- R10: When power-down and stop are both accepted, power-down wins. All outputs park, and the parked form follows `cfg_pd_tristate`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pol_pin | input | 1 | Pin polarity select, latched during reset |
| pd_pin | input | 1 | Asynchronous power-down request pin |
| stop_pin | input | 1 | Asynchronous stop request pin |
| oe_pin | input | N_OUT | Per-output enable pins |
| cfg_en | input | N_OUT | Per-output enable configuration bits |
| cfg_stoppable | input | N_OUT | 1 = output obeys stop, 0 = free-running |
| cfg_pd_tristate | input | 1 | Power-down parked form: 0 driven high, 1 undriven |
| cfg_stop_tristate | input | 1 | Stop parked form: 0 driven high, 1 undriven |
| cfg_req_inv | input | 1 | Inverts the sense of both requests |
| dif_t | output | N_OUT | True leg values |
| dif_t_oe | output | N_OUT | True leg drive enables |
| dif_c | output | N_OUT | Complement leg values |
| dif_c_oe | output | N_OUT | Complement leg drive enables |

## Verification
A wrong filter state shows up as parking or restart moving by one output period, so a cycle-exact comparison catches it within two clocks of the expected edge. A wrong per-output park or enable register shows up on the very next clock, either as a leg driven that should float or as a leg frozen high while it should toggle. The restart window and the ignored single-sample pulse are also measured directly at the legs.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    typedef enum logic [1:0] {
        PARK_NONE = 2'd0,
        PARK_PD   = 2'd1,
        PARK_STOP = 2'd2
    } park_e;

    typedef struct packed {
        logic t_val;
        logic t_oe;
        logic c_val;
        logic c_oe;
    } pair_drv_t;

    localparam pair_drv_t DRV_OFF = '0;

    // Active level of a request pin after polarity and inversion
    function automatic logic req_level(input logic pin, input logic pol, input logic inv);
        return (pol ? pin : ~pin) ^ inv;
    endfunction

    // Active level of an enable pin after polarity
    function automatic logic oe_level(input logic pin, input logic pol);
        return pol ? ~pin : pin;
    endfunction

endpackage

// File: rtl/clkstop_req_sync.sv
module clkstop_req_sync (
    input  logic clk,
    input  logic rst,
    input  logic samp,
    input  logic req,
    output logic acc
);
    logic hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= 1'b0;
            acc  <= 1'b0;
        end else if (samp) begin
            hist <= req;
            if (hist == req) acc <= req;
        end
    end

    // R2: accepted state moves only on a sample edge and only to the level seen on the prior sample
    a_r2_two_samples: assert property (@(posedge clk) disable iff (rst)
        (acc != $past(acc)) |-> ($past(samp) && ($past(hist) == acc)));

endmodule

// File: rtl/clkstop_lane.sv
module clkstop_lane
    import clkstop_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      src_ph,
    input  logic      pd_acc,
    input  logic      stop_acc,
    input  logic      stoppable,
    input  logic      en_req,
    input  logic      pd_tri,
    input  logic      stop_tri,
    output pair_drv_t drv_o
);
    park_e park_q;
    logic  en_q;
    logic  undriven;

    always_ff @(posedge clk) begin
        if (rst) begin
            park_q <= PARK_NONE;
            en_q   <= 1'b0;
        end else if (!src_ph) begin
            if (pd_acc)                      park_q <= PARK_PD;
            else if (stop_acc && stoppable)  park_q <= PARK_STOP;
            else                             park_q <= PARK_NONE;
            en_q <= en_req;
        end
    end

    always_comb begin
        undriven = (park_q == PARK_PD) ? pd_tri : stop_tri;
        drv_o    = DRV_OFF;
        if (en_q) begin
            if (park_q == PARK_NONE) begin
                drv_o.t_val = src_ph;
                drv_o.t_oe  = 1'b1;
                drv_o.c_val = ~src_ph;
                drv_o.c_oe  = 1'b1;
            end else begin
                drv_o.t_val = ~undriven;
                drv_o.t_oe  = ~undriven;
            end
        end
    end

    // R4/R5: park state only moves on a complement-falling edge
    a_r4_park_on_fall: assert property (@(posedge clk) disable iff (rst)
        (park_q != $past(park_q)) |-> !$past(src_ph));

    // R10: power-down parking is never overridden by stop
    a_r10_pd_wins: assert property (@(posedge clk) disable iff (rst)
        ($past(pd_acc) && !$past(src_ph)) |-> (park_q == PARK_PD));

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int N_OUT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pol_pin,
    input  logic             pd_pin,
    input  logic             stop_pin,
    input  logic [N_OUT-1:0] oe_pin,
    input  logic [N_OUT-1:0] cfg_en,
    input  logic [N_OUT-1:0] cfg_stoppable,
    input  logic             cfg_pd_tristate,
    input  logic             cfg_stop_tristate,
    input  logic             cfg_req_inv,
    output logic [N_OUT-1:0] dif_t,
    output logic [N_OUT-1:0] dif_t_oe,
    output logic [N_OUT-1:0] dif_c,
    output logic [N_OUT-1:0] dif_c_oe
);
    logic src_ph;
    logic pol_q;
    logic pd_acc;
    logic stop_acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_ph <= 1'b0;
            pol_q  <= pol_pin;
        end else begin
            src_ph <= ~src_ph;
        end
    end

    clkstop_req_sync u_pd_sync (
        .clk  (clk),
        .rst  (rst),
        .samp (src_ph),
        .req  (req_level(pd_pin, pol_q, cfg_req_inv)),
        .acc  (pd_acc)
    );

    clkstop_req_sync u_stop_sync (
        .clk  (clk),
        .rst  (rst),
        .samp (src_ph),
        .req  (req_level(stop_pin, pol_q, cfg_req_inv)),
        .acc  (stop_acc)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_lane
        pair_drv_t drv;

        clkstop_lane u_lane (
            .clk       (clk),
            .rst       (rst),
            .src_ph    (src_ph),
            .pd_acc    (pd_acc),
            .stop_acc  (stop_acc),
            .stoppable (cfg_stoppable[g]),
            .en_req    (cfg_en[g] & oe_level(oe_pin[g], pol_q)),
            .pd_tri    (cfg_pd_tristate),
            .stop_tri  (cfg_stop_tristate),
            .drv_o     (drv)
        );

        assign dif_t[g]    = drv.t_val;
        assign dif_t_oe[g] = drv.t_oe;
        assign dif_c[g]    = drv.c_val;
        assign dif_c_oe[g] = drv.c_oe;

        // R3: two driven legs are always opposite
        a_r3_legs_opposite: assert property (@(posedge clk) disable iff (rst)
            (dif_t_oe[g] && dif_c_oe[g]) |-> (dif_t[g] != dif_c[g]));

        // R8: a cleared enable bit seen on a falling boundary silences both legs
        a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
            ($past(!cfg_en[g]) && $past(!src_ph)) |-> (!dif_t_oe[g] && !dif_c_oe[g]));
    end

    // R1: latched polarity only moves on a reset cycle
    a_r1_pol_latched: assert property (@(posedge clk) disable iff (rst)
        (pol_q != $past(pol_q)) |-> $past(rst));

endmodule

// File: tb/test_clkstop_ctrl.sv
module test_clkstop_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pol_pin = 1'b0;
    logic pd_pin = 1'b1;
    logic stop_pin = 1'b1;
    logic [N-1:0] oe_pin = '1;
    logic [N-1:0] cfg_en = '1;
    logic [N-1:0] cfg_stoppable = 4'b0110;
    logic cfg_pd_tristate = 1'b0;
    logic cfg_stop_tristate = 1'b0;
    logic cfg_req_inv = 1'b0;
    logic [N-1:0] dif_t, dif_t_oe, dif_c, dif_c_oe;

    int vectors = 0;
    int miscompares = 0;
    string cur_req = "R1";

    clkstop_ctrl #(.N_OUT(N)) i_clkstop_ctrl (
        .clk(clk), .rst(rst), .pol_pin(pol_pin), .pd_pin(pd_pin), .stop_pin(stop_pin),
        .oe_pin(oe_pin), .cfg_en(cfg_en), .cfg_stoppable(cfg_stoppable),
        .cfg_pd_tristate(cfg_pd_tristate), .cfg_stop_tristate(cfg_stop_tristate),
        .cfg_req_inv(cfg_req_inv), .dif_t(dif_t), .dif_t_oe(dif_t_oe),
        .dif_c(dif_c), .dif_c_oe(dif_c_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: output clock count, request history, per-output flags
    int  m_cycle;
    bit  m_pol;
    bit  m_pd_last, m_st_last, m_pd_on, m_st_on;
    bit  m_park [N];
    bit  m_bypd [N];
    bit  m_en   [N];

    always @(posedge clk) begin
        bit pd_now, st_now, odd;
        if (rst) begin
            m_cycle = 0; m_pol = pol_pin;
            m_pd_last = 0; m_st_last = 0; m_pd_on = 0; m_st_on = 0;
            for (int i = 0; i < N; i++) begin m_park[i] = 0; m_bypd[i] = 0; m_en[i] = 0; end
        end else begin
            pd_now = (m_pol ? pd_pin : !pd_pin) ^ cfg_req_inv;
            st_now = (m_pol ? stop_pin : !stop_pin) ^ cfg_req_inv;
            odd = (m_cycle % 2) == 1;
            if (odd) begin
                if (pd_now == m_pd_last) m_pd_on = pd_now;
                if (st_now == m_st_last) m_st_on = st_now;
                m_pd_last = pd_now;
                m_st_last = st_now;
            end else begin
                for (int i = 0; i < N; i++) begin
                    m_park[i] = m_pd_on || (m_st_on && cfg_stoppable[i]);
                    m_bypd[i] = m_pd_on;
                    m_en[i]   = cfg_en[i] && (m_pol ? !oe_pin[i] : oe_pin[i]);
                end
            end
            m_cycle++;
        end
        #(CLK_PERIOD/4);
        begin
            logic [N-1:0] et, eto, ec, eco;
            bit ph, tri_s;
            ph = (m_cycle % 2) == 1;
            for (int i = 0; i < N; i++) begin
                et[i] = 0; eto[i] = 0; ec[i] = 0; eco[i] = 0;
                if (m_en[i]) begin
                    if (!m_park[i]) begin
                        et[i] = ph; eto[i] = 1; ec[i] = !ph; eco[i] = 1;
                    end else begin
                        tri_s = m_bypd[i] ? cfg_pd_tristate : cfg_stop_tristate;
                        et[i] = !tri_s; eto[i] = !tri_s;
                    end
                end
            end
            chk(cur_req, "legs{t,t_oe,c,c_oe}", {16'd0, dif_t, dif_t_oe, dif_c, dif_c_oe},
                {16'd0, et, eto, ec, eco});
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic pol);
        @(negedge clk);
        rst = 1'b1; pol_pin = pol;
        run(3);
        cur_req = "R1";
        chk("R1", "reset legs", {28'd0, |dif_t, |dif_t_oe, |dif_c, |dif_c_oe}, 32'd0);
        rst = 1'b0;
    endtask

    // Count negedges until lane's true leg reads 0
    task automatic measure_fall(input int lane, output int n);
        n = 0;
        while (n < 30) begin
            @(negedge clk);
            n++;
            if (dif_t[lane] === 1'b0) break;
        end
    endtask

    task automatic measure_park(input int lane, output int n);
        n = 0;
        while (n < 30) begin
            @(negedge clk);
            n++;
            if (dif_c_oe[lane] === 1'b0) break;
        end
    endtask

    initial begin
        int n, toggles;
        logic last;
        // polarity 0: enables active-high, requests active-low
        do_reset(1'b0);
        cur_req = "R3"; run(20);

        // stop, driven parking; lanes 0 and 3 free-run (R6)
        cur_req = "R5"; stop_pin = 1'b0; run(30);
        chk("R6", "free-run lane0 still driven complement", {31'd0, dif_c_oe[0]}, 32'd1);
        chk("R5", "stoppable lane1 parked high", {30'd0, dif_t[1], dif_c_oe[1]}, 32'h2);
        cur_req = "R7"; stop_pin = 1'b1;
        measure_fall(1, n);
        chk("R7", "restart clocks in 4..12", {31'd0, (n >= 4 && n <= 12)}, 32'd1);
        run(20);

        // stop, undriven parking
        cfg_stop_tristate = 1'b1;
        cur_req = "R5"; stop_pin = 1'b0; run(30);
        chk("R5", "tristate stop lane2 undriven", {30'd0, dif_t_oe[2], dif_c_oe[2]}, 32'd0);
        stop_pin = 1'b1; run(20);

        // single-sample power-down pulse is filtered
        cur_req = "R2";
        @(negedge clk); while (i_clkstop_ctrl.dif_t[0] !== 1'b1) @(negedge clk);
        pd_pin = 1'b0; run(2); pd_pin = 1'b1;
        toggles = 0; last = dif_t[0];
        repeat (10) begin @(negedge clk); if (dif_t[0] !== last) toggles++; last = dif_t[0]; end
        chk("R2", "short pulse ignored toggles", toggles, 32'd10);

        // power-down driven parking, timing of the parking edge
        cur_req = "R4"; pd_pin = 1'b0;
        measure_park(0, n);
        chk("R4", "pd parks within 3..6 clocks", {31'd0, (n >= 3 && n <= 6)}, 32'd1);
        run(20);
        chk("R4", "pd drives true high on all", {28'd0, dif_t}, 32'hF);
        // both requests: power-down form wins
        cur_req = "R10"; stop_pin = 1'b0; cfg_pd_tristate = 1'b1; cfg_stop_tristate = 1'b0; run(20);
        chk("R10", "pd form used while stop also accepted", {28'd0, dif_t_oe}, 32'd0);
        pd_pin = 1'b1; run(20);
        stop_pin = 1'b1; run(20);

        // enable via configuration bit and via pin
        cur_req = "R8"; cfg_en[3] = 1'b0; run(10);
        chk("R8", "cfg disabled lane3", {30'd0, dif_t_oe[3], dif_c_oe[3]}, 32'd0);
        cfg_en[3] = 1'b1; oe_pin[0] = 1'b0; pd_pin = 1'b0; run(20);
        chk("R8", "pin disabled lane0 during pd", {30'd0, dif_t_oe[0], dif_c_oe[0]}, 32'd0);
        pd_pin = 1'b1; oe_pin[0] = 1'b1; run(20);

        // request inversion: pins idle low now
        cur_req = "R9"; cfg_req_inv = 1'b1; pd_pin = 1'b0; stop_pin = 1'b0; run(20);
        stop_pin = 1'b1; run(20);
        chk("R9", "inverted stop parks lane1", {31'd0, dif_c_oe[1]}, 32'd0);
        stop_pin = 1'b0; run(20);
        cfg_req_inv = 1'b0; pd_pin = 1'b1; stop_pin = 1'b1;

        // polarity 1: enables active-low, requests active-high
        oe_pin = '0; pd_pin = 1'b0; stop_pin = 1'b0;
        do_reset(1'b1);
        cur_req = "R1"; pol_pin = 1'b0; run(20);
        chk("R1", "pol change after reset ignored", {31'd0, dif_c_oe[2]}, 32'd1);
        cur_req = "R9"; stop_pin = 1'b1; run(20);
        chk("R9", "active-high stop parks lane2", {31'd0, dif_c_oe[2]}, 32'd0);
        stop_pin = 1'b0; oe_pin[1] = 1'b1; run(20);
        chk("R9", "active-low enable pin off lane1", {31'd0, dif_t_oe[1]}, 32'd0);
        pd_pin = 1'b1; run(20);
        pd_pin = 1'b0; run(20);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        miscompares++;
        $display("FAIL watchdog run did not end actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule